// File: doc/BRIEF.md
# Dynamic Per-Bank Refresh Scheduler

This block sits in a DRAM memory controller and decides when a per-bank refresh goes out to a rank, and which bank receives it. A fixed bank sequence is not used. The controller picks the target from moment to moment, and it favours banks whose request queues are empty. Refreshes that would disturb demand traffic are held back against a bounded credit of owed refreshes. While the controller drains a batch of writes, refreshes are pulled in ahead of schedule.

A periodic interval tick adds one owed refresh, and every issued refresh removes one. When the debt reaches its ceiling, a refresh is forced even to a bank with queued requests. Only one bank refreshes at a time. Each refreshing bank is held unavailable for a programmable number of cycles, and the other banks keep working. A round mask stops any bank from being refreshed twice before every bank has had its turn. A rotating pointer breaks ties among equally eligible banks.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_req` is 0 and `bank_refreshing` is all zeros. The owed count is 0, the round mask is empty and the rotation pointer is at bank 0, so the first refresh after a single tick with all banks idle goes to bank 0.
- R2: Each cycle with `refi_tick` high adds one owed refresh, and each `ref_req` strobe removes one. A tick sampled at clock edge k can produce a strobe at edge k+1 at the earliest.
- R3: Outside write drain and below the ceiling, a refresh is issued only while the owed count is positive and a candidate bank has `bank_pending` low. If every candidate has `bank_pending` high, the refresh is deferred.
- R4: When the owed count equals MAX_OWED, a refresh is issued to a candidate even if that bank has `bank_pending` high. Idle candidates still win when there are any.
- R5: While `write_drain` is high, refreshes are issued ahead of schedule as long as the owed count is above -MAX_PULL. Idle candidates are preferred, and otherwise any candidate is used.
- R6: At most one bit of `bank_refreshing` is set. The bit for `ref_bank` rises with the strobe and stays high for exactly `trfc_cycles` cycles, or for 1 cycle when `trfc_cycles` is 0.
- R7: A bank is not refreshed again until every bank has been refreshed once in the current round. The round mask clears when its last bank is refreshed.
- R8: Among the banks in the chosen pool, the pick is the first one found scanning upward (with wrap) from the bank after the previously refreshed one.
- R9: A bank with `bank_busy` high in the deciding cycle is never selected.
- R10: The owed count never exceeds MAX_OWED. Ticks that arrive at the ceiling are dropped.
- R11: `ref_req` is a one-cycle pulse. The next refresh is decided no earlier than the first cycle after `bank_refreshing` returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refi_tick | input | 1 | One pulse per refresh interval; adds one owed refresh |
| trfc_cycles | input | TRFC_W | Cycles a bank stays under refresh (0 treated as 1) |
| bank_pending | input | NUM_BANKS | Per-bank flag: demand requests are queued |
| bank_busy | input | NUM_BANKS | Per-bank flag: timing forbids a refresh now |
| write_drain | input | 1 | Controller is draining a write batch |
| ref_req | output | 1 | One-cycle refresh strobe |
| ref_bank | output | $clog2(NUM_BANKS) | Bank that the strobe refreshes |
| bank_refreshing | output | NUM_BANKS | Per-bank flag: bank is under refresh |

## Verification
The bench builds the block with 4 banks, MAX_OWED of 3, MAX_PULL of 2 and a 4-bit refresh-length field. At this size the credit ceiling, the pull-in floor and a complete refresh round are each only a few strobes away, so every cycle of long mixed stimulus reaches them many times. Directed scenarios count strobes across deferral, saturation with every bank blocked, and pull-in during drain. A cycle-level reference model then checks the strobe, the bank index and the per-bank refresh flags through phases of heavy queueing, blocked banks and drain.

// File: rtl/refresh_sched_pkg.sv
// Shared types for the per-bank refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package refresh_sched_pkg;
    // Reason a refresh is issued in the current cycle.
    typedef enum logic [1:0] {
        ISSUE_NONE   = 2'd0,
        ISSUE_IDLE   = 2'd1,
        ISSUE_FORCED = 2'd2,
        ISSUE_DRAIN  = 2'd3
    } issue_reason_t;
endpackage

// File: rtl/refresh_credit.sv
// Signed owed-refresh counter. Ticks add, issued refreshes subtract,
// and the count saturates at MAX_OWED. The lower bound is kept by the
// caller: it issues early only while can_pull is high.
// Assumes: issue is never asserted while the count is at -MAX_PULL.
module refresh_credit #(
    parameter int MAX_OWED = 8,
    parameter int MAX_PULL = 8,
    parameter int CW = $clog2(((MAX_OWED > MAX_PULL) ? MAX_OWED : MAX_PULL) + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 issue,
    output logic signed [CW-1:0] owed,
    output logic                 forced,
    output logic                 positive,
    output logic                 can_pull
);
    localparam logic signed [CW-1:0] OWED_TOP = CW'(MAX_OWED);
    localparam logic signed [CW-1:0] PULL_BOT = -CW'(MAX_PULL);

    logic signed [CW-1:0] owed_d;

    // Next count: add tick, subtract issue, clip at the ceiling.
    always_comb begin
        int nxt;
        nxt = int'(owed) + int'(tick) - int'(issue);
        if (nxt > MAX_OWED) nxt = MAX_OWED;
        owed_d = CW'(nxt);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) owed <= '0;
        else        owed <= owed_d;
    end

    assign forced   = (owed >= OWED_TOP);
    assign positive = (owed > 0);
    assign can_pull = (owed > PULL_BOT);
endmodule

// File: rtl/bank_timers.sv
// One down-counter per bank. It holds the bank under refresh for a
// programmed number of cycles, and a length of 0 is taken as 1.
// Assumes: start picks one bank at a time.
module bank_timers #(
    parameter int NB = 8,
    parameter int TW = 8,
    parameter int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] start_bank,
    input  logic [TW-1:0] trfc,
    output logic [NB-1:0] refreshing
);
    logic [TW-1:0] load_val;

    // Length to load, never zero.
    assign load_val = (trfc == '0) ? TW'(1) : trfc;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [TW-1:0] cnt;

        // Load on start for this bank, else count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    cnt <= '0;
            else if (start && (start_bank == BW'(b)))      cnt <= load_val;
            else if (cnt != '0)                            cnt <= cnt - TW'(1);
        end

        assign refreshing[b] = (cnt != '0);
    end
endmodule

// File: rtl/rotate_pick.sv
// Rotating-priority selector: returns the first set bit of pool found
// scanning upward from ptr, wrapping past the top bank.
// Assumes: ptr < NB.
module rotate_pick #(
    parameter int NB = 8,
    parameter int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0] pool,
    input  logic [BW-1:0] ptr,
    output logic          found,
    output logic [BW-1:0] sel
);
    // Scan from the pointer and keep the first hit.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NB; i++) begin
            int idx;
            idx = (int'(ptr) + i) % NB;
            if (!found && pool[idx]) begin
                found = 1'b1;
                sel   = BW'(idx);
            end
        end
    end
endmodule

// File: rtl/refresh_sched.sv
// Dynamic per-bank refresh scheduler. Picks the target bank out of
// order: idle banks first, forced at the credit ceiling, pulled in
// while writes drain. One bank refreshes at a time, and a round mask
// keeps every bank's turn.
// Assumes: trfc_cycles is stable while a refresh is being started.
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int MAX_OWED  = 8,
    parameter int MAX_PULL  = 8,
    parameter int TRFC_W    = 8,
    parameter int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int CW = $clog2(((MAX_OWED > MAX_PULL) ? MAX_OWED : MAX_PULL) + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refi_tick,
    input  logic [TRFC_W-1:0]    trfc_cycles,
    input  logic [NUM_BANKS-1:0] bank_pending,
    input  logic [NUM_BANKS-1:0] bank_busy,
    input  logic                 write_drain,
    output logic                 ref_req,
    output logic [BW-1:0]        ref_bank,
    output logic [NUM_BANKS-1:0] bank_refreshing
);
    logic signed [CW-1:0]   owed_q;
    logic                   forced, positive, can_pull;
    logic [NUM_BANKS-1:0]   done_q, done_d;
    logic [BW-1:0]          ptr_q;
    logic [NUM_BANKS-1:0]   cand, idle, pool;
    logic                   any_ref, found, issue;
    logic [BW-1:0]          sel;
    issue_reason_t          reason;

    refresh_credit #(.MAX_OWED(MAX_OWED), .MAX_PULL(MAX_PULL), .CW(CW)) u_credit (
        .clk(clk), .rst_n(rst_n), .tick(refi_tick), .issue(issue),
        .owed(owed_q), .forced(forced), .positive(positive), .can_pull(can_pull)
    );

    bank_timers #(.NB(NUM_BANKS), .TW(TRFC_W), .BW(BW)) u_timers (
        .clk(clk), .rst_n(rst_n), .start(issue), .start_bank(sel),
        .trfc(trfc_cycles), .refreshing(bank_refreshing)
    );

    rotate_pick #(.NB(NUM_BANKS), .BW(BW)) u_pick (
        .pool(pool), .ptr(ptr_q), .found(found), .sel(sel)
    );

    // Candidate banks: not yet done this round and not timing-blocked.
    assign cand    = ~done_q & ~bank_busy;
    assign idle    = cand & ~bank_pending;
    assign pool    = (|idle) ? idle : cand;
    assign any_ref = |bank_refreshing;

    // Decide whether a refresh goes out this cycle, and why.
    always_comb begin
        reason = ISSUE_NONE;
        if (!any_ref) begin
            if (positive && (|idle))                      reason = ISSUE_IDLE;
            else if (forced && (|cand))                   reason = ISSUE_FORCED;
            else if (write_drain && can_pull && (|cand))  reason = ISSUE_DRAIN;
        end
    end

    assign issue = (reason != ISSUE_NONE) && found;

    // Round mask after this cycle's pick, cleared once every bank is done.
    always_comb begin
        done_d = done_q;
        if (issue) done_d = done_q | (NUM_BANKS'(1) << sel);
        if (&done_d) done_d = '0;
    end

    // Strobe, bank index, round mask and rotation pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_req  <= 1'b0;
            ref_bank <= '0;
            done_q   <= '0;
            ptr_q    <= '0;
        end else begin
            ref_req <= issue;
            done_q  <= done_d;
            if (issue) begin
                ref_bank <= sel;
                ptr_q    <= (sel == BW'(NUM_BANKS - 1)) ? '0 : sel + BW'(1);
            end
        end
    end
endmodule

// File: rtl/refresh_sched_checker.sv
// Property checker for refresh_sched, attached with bind below.
// Assumes: connected to the scheduler's own clock and reset.
module refresh_sched_checker #(
    parameter int NB = 8,
    parameter int BW = 3,
    parameter int CW = 5,
    parameter int MAX_OWED = 8,
    parameter int MAX_PULL = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_req,
    input logic [BW-1:0]        ref_bank,
    input logic [NB-1:0]        bank_refreshing,
    input logic [NB-1:0]        bank_busy,
    input logic signed [CW-1:0] owed_q,
    input logic [NB-1:0]        done_q
);
    logic [NB-1:0] busy_d, done_prev;

    // Previous-cycle copies of the busy flags and round mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d    <= '0;
            done_prev <= '0;
        end else begin
            busy_d    <= bank_busy;
            done_prev <= done_q;
        end
    end

    AST_ONE_REFRESHING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_refreshing)); // R6
    AST_STROBE_MARKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> bank_refreshing[ref_bank]); // R6
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !ref_req); // R11
    AST_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !busy_d[ref_bank]); // R9
    AST_ROUND_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !done_prev[ref_bank]); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_q <= CW'(MAX_OWED)) && (owed_q >= -CW'(MAX_PULL))); // R10
endmodule

bind refresh_sched refresh_sched_checker #(
    .NB(NUM_BANKS), .BW(BW), .CW(CW), .MAX_OWED(MAX_OWED), .MAX_PULL(MAX_PULL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_bank(ref_bank),
    .bank_refreshing(bank_refreshing), .bank_busy(bank_busy),
    .owed_q(owed_q), .done_q(done_q)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int NB   = 4;
    localparam int MAXO = 3;
    localparam int MAXP = 2;
    localparam int TW   = 4;
    localparam int BW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refi_tick = 1'b0;
    logic [TW-1:0] trfc_cycles = 4'd3;
    logic [NB-1:0] bank_pending = '0;
    logic [NB-1:0] bank_busy = '0;
    logic          write_drain = 1'b0;
    logic          ref_req;
    logic [BW-1:0] ref_bank;
    logic [NB-1:0] bank_refreshing;

    int n_checks = 0;
    int n_fail   = 0;
    int strobes  = 0;
    string cur_tag = "R2";

    always #2.5 clk = ~clk;

    refresh_sched #(.NUM_BANKS(NB), .MAX_OWED(MAXO), .MAX_PULL(MAXP), .TRFC_W(TW)) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .refi_tick(refi_tick), .trfc_cycles(trfc_cycles),
        .bank_pending(bank_pending), .bank_busy(bank_busy), .write_drain(write_drain),
        .ref_req(ref_req), .ref_bank(ref_bank), .bank_refreshing(bank_refreshing)
    );

    // Reference model of the requirements, advanced on each rising edge.
    int     m_owed;
    bit [NB-1:0] m_done;
    int     m_ptr;
    int     m_cnt [NB];
    bit     m_req;
    int     m_bank;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_owed = 0; m_done = '0; m_ptr = 0; m_req = 0; m_bank = 0;
            for (int b = 0; b < NB; b++) m_cnt[b] = 0;
        end else begin
            bit busy_any, go;
            bit [NB-1:0] c, idl, pl;
            int pick, len;
            busy_any = 0;
            for (int b = 0; b < NB; b++) if (m_cnt[b] > 0) busy_any = 1;
            c   = ~m_done & ~bank_busy;
            idl = c & ~bank_pending;
            pl  = (idl != 0) ? idl : c;
            go  = !busy_any && (((m_owed > 0) && idl != 0) || ((m_owed >= MAXO) && c != 0)
                  || (write_drain && (m_owed > -MAXP) && c != 0));
            pick = -1;
            for (int i = 0; i < NB; i++)
                if (pick < 0 && pl[(m_ptr + i) % NB]) pick = (m_ptr + i) % NB;
            for (int b = 0; b < NB; b++) if (m_cnt[b] > 0) m_cnt[b] = m_cnt[b] - 1;
            m_owed = m_owed + (refi_tick ? 1 : 0) - (go ? 1 : 0);
            if (m_owed > MAXO) m_owed = MAXO;
            m_req = go;
            if (go) begin
                len = (trfc_cycles == 0) ? 1 : int'(trfc_cycles);
                m_cnt[pick] = len;
                m_bank = pick;
                m_done[pick] = 1'b1;
                if (m_done == '1) m_done = '0;
                m_ptr = (pick + 1) % NB;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to the next falling edge, compare against the model, count strobes.
    task automatic step();
        bit [NB-1:0] er;
        @(negedge clk);
        for (int b = 0; b < NB; b++) er[b] = (m_cnt[b] > 0);
        chk(ref_req == m_req, cur_tag, int'(ref_req), int'(m_req));
        chk(bank_refreshing == er, "R6", int'(bank_refreshing), int'(er));
        if (m_req) chk(int'(ref_bank) == m_bank, "R8", int'(ref_bank), m_bank);
        if (ref_req) strobes++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(ref_req == 1'b0, "R1", int'(ref_req), 0);
        chk(bank_refreshing == '0, "R1", int'(bank_refreshing), 0);

        // R1/R2/R8: one tick with all banks idle, strobe to bank 0 one edge later
        refi_tick = 1'b1;
        step(); refi_tick = 1'b0;
        chk(ref_req == 1'b0, "R2", int'(ref_req), 0);
        step();
        chk(ref_req == 1'b1, "R2", int'(ref_req), 1);
        chk(ref_bank == 2'd0, "R8", int'(ref_bank), 0);
        chk(bank_refreshing == 4'b0001, "R6", int'(bank_refreshing), 1);
        run(10);

        // R3: deferred while every bank has queued work, released when idle
        cur_tag = "R3";
        bank_pending = '1;
        refi_tick = 1'b1; step(); step(); refi_tick = 1'b0;
        s0 = strobes; run(40);
        chk(strobes == s0, "R3", strobes - s0, 0);
        bank_pending = '0;
        s0 = strobes; run(40);
        chk(strobes - s0 == 2, "R3", strobes - s0, 2);

        // R10/R4: saturate with all banks blocked, then drain exactly MAXO
        cur_tag = "R10";
        bank_busy = '1; bank_pending = '1;
        refi_tick = 1'b1; run(10); refi_tick = 1'b0;
        bank_busy = '0;
        s0 = strobes; run(30);
        chk(strobes - s0 == 1, "R4", strobes - s0, 1);
        bank_pending = '0;
        run(60);
        chk(strobes - s0 == MAXO, "R10", strobes - s0, MAXO);

        // R5: write drain pulls ahead exactly MAXP refreshes
        cur_tag = "R5";
        write_drain = 1'b1;
        s0 = strobes; run(100);
        chk(strobes - s0 == MAXP, "R5", strobes - s0, MAXP);
        write_drain = 1'b0;
        bank_pending = '1;
        refi_tick = 1'b1; step(); step(); refi_tick = 1'b0;
        bank_pending = '0;
        run(30);

        // Mixed sweeps against the model
        for (int ph = 0; ph < 6; ph++) begin
            case (ph)
                0: cur_tag = "R3/R8";
                1: cur_tag = "R4";
                2: cur_tag = "R5";
                3: cur_tag = "R9";
                4: cur_tag = "R10";
                default: cur_tag = "R7/R11";
            endcase
            for (int i = 0; i < 3000; i++) begin
                step();
                trfc_cycles  = TW'($urandom_range(0, 5));
                refi_tick    = ($urandom_range(0, 99) < ((ph == 1 || ph == 4) ? 40 : 8));
                bank_pending = (ph == 1 || ph == 4) ? NB'($urandom | $urandom) : NB'($urandom);
                bank_busy    = (ph == 3) ? NB'($urandom) : ((ph == 4) ? NB'($urandom | $urandom) : '0);
                write_drain  = (ph == 2) ? ($urandom_range(0, 3) != 0) : ((ph == 5) && $urandom_range(0, 1) == 1);
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule